// File: doc/BRIEF.md
# Linear Flash Card Access Decoder

This block is the card-side decode logic for a removable linear flash card with a 16-bit PC Card style host bus. The host presents an address, two active-low byte enables, read and write strobes, a plane select and a write-protect level. From these the block produces three groups of outputs. The first is a low-byte and a high-byte chip select for each pair of byte-wide 512 KB flash devices. The second is the 19-bit device address and a select for the small attribute memory. The third is the controls for the card's data buffers: tristate enables per lane, a steering flag that routes the odd byte over the low lane, and per-lane flags that tell the buffers to drive all-ones.

The host pins are sampled on the card clock, and every output is registered, so outputs follow inputs by one clock. The number of populated device pairs (`NUM_PAIRS`) may be 1 to 10. Pair selection uses address bits 20 and up, masked to the next power of two, so smaller cards alias at that boundary.

Top module: `flc_dec`

## Requirements
- R1: With both enables high (standby), no flash chip select and no attribute select is active, and both lane enables are low.
- R2: With the low enable active, the high enable inactive and address bit 0 low, only the even byte is targeted: low-byte selects only, and a read enables only the low lane, with no steering.
- R3: With the low enable active, the high enable inactive and address bit 0 high, only the odd byte is targeted. High-byte selects are used, a read enables only the low lane, and `steer_odd_o` is 1.
- R4: With both enables active, the access is a word access and address bit 0 has no effect. Both byte selects are used, and a read enables both lanes.
- R5: With the high enable active and the low enable inactive, only the odd byte is targeted. A read enables only the high lane, and steering is 0.
- R6: A read cycle is `oe_ni`=0 with `we_ni`=1. A write cycle is `we_ni`=0 with `oe_ni`=1. Any other strobe combination activates no select, `rd_no` or `wr_no`.
- R7: With `reg_ni`=1, the selected pair index is `addr_i[23:20]` ANDed with (2^ceil(log2 NUM_PAIRS))-1. At most one low-byte and one high-byte select is active. `arr_addr_o` equals `addr_i[19:1]`.
- R8: If the masked pair index is at least NUM_PAIRS, no flash select is active. During a read, the fill flag of every enabled lane is set.
- R9: With `wp_i`=1, a flash-plane write keeps `wr_no` high. Attribute-plane writes are not blocked by `wp_i`.
- R10: With `reg_ni`=0, no flash select is active. `attr_cs_no` is active only for cycles that target the even byte. Odd-byte read positions set the fill flag of their lane.
- R11: `wait_no` is always 1.
- R12: During reset all selects and strobes are high and all enables and flags are 0. Outputs reflect inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Card clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 26 | Host address |
| ce1_ni | input | 1 | Even-byte enable, active low |
| ce2_ni | input | 1 | Odd-byte enable, active low |
| oe_ni | input | 1 | Read strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| reg_ni | input | 1 | Plane select: 1 flash, 0 attribute |
| wp_i | input | 1 | Write protect, high blocks flash writes |
| cs_lo_no | output | NUM_PAIRS | Low-byte device selects per pair, active low |
| cs_hi_no | output | NUM_PAIRS | High-byte device selects per pair, active low |
| arr_addr_o | output | 19 | Device address |
| attr_cs_no | output | 1 | Attribute memory select, active low |
| rd_no | output | 1 | Device read strobe, active low |
| wr_no | output | 1 | Device write strobe, active low |
| lane_lo_oe_o | output | 1 | Drive low data lane |
| lane_hi_oe_o | output | 1 | Drive high data lane |
| steer_odd_o | output | 1 | Route odd byte through the low lane |
| fill_lo_o | output | 1 | Low lane drives all-ones |
| fill_hi_o | output | 1 | High lane drives all-ones |
| wait_no | output | 1 | Wait request, held inactive |

## Verification
The bench uses three pairs, so the wrap mask is 3. It sweeps every combination of enables, address bit 0, strobes, plane and write protect against all sixteen values of the pair field. Index 3 exercises the unpopulated hole, and indices 4 to 15 exercise aliasing. A decoder that wrapped modulo the pair count, or that did not mask at all, would select the wrong pair or no pair. A decoder that ignored the hole would select a device that does not exist. The sweep also covers odd attribute accesses. An attribute write at an odd position that reached the memory would corrupt an even byte. A write-protect that also blocked attribute writes would stop the card information from being programmed. A read with both strobes low that was not suppressed would let the buffers fight the host.

// File: rtl/flc_dec_pkg.sv
package flc_dec_pkg;
  localparam int MAX_PAIRS = 10;
  localparam int ARR_AW    = 19;
  localparam int IDX_W     = $clog2(MAX_PAIRS);

  typedef struct packed {
    logic even;
    logic odd;
    logic steer;
  } lane_need_t;
endpackage

// File: rtl/flc_lane_dec.sv
module flc_lane_dec
  import flc_dec_pkg::*;
(
  input  logic       ce1_ni,
  input  logic       ce2_ni,
  input  logic       a0_i,
  output lane_need_t need_o
);
  always_comb begin
    need_o.even  = !ce1_ni && (!ce2_ni || !a0_i);
    need_o.odd   = !ce2_ni || (!ce1_ni && a0_i);
    need_o.steer = !ce1_ni && ce2_ni && a0_i;
  end
endmodule

// File: rtl/flc_pair_dec.sv
module flc_pair_dec
  import flc_dec_pkg::*;
#(
  parameter int NUM_PAIRS = 3
) (
  input  logic [IDX_W-1:0]     field_i,
  input  logic                 en_i,
  output logic [NUM_PAIRS-1:0] sel_o,
  output logic                 populated_o
);
  localparam int WRAP_LOG = $clog2(NUM_PAIRS);
  localparam logic [IDX_W-1:0] WRAP_MASK = IDX_W'((1 << WRAP_LOG) - 1);

  logic [IDX_W-1:0] idx;
  assign idx         = field_i & WRAP_MASK;
  assign populated_o = int'(idx) < NUM_PAIRS;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign sel_o[p] = en_i && (idx == IDX_W'(p));
  end
endmodule

// File: rtl/flc_dec.sv
module flc_dec
  import flc_dec_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int ADDR_W    = 26
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 ce1_ni,
  input  logic                 ce2_ni,
  input  logic                 oe_ni,
  input  logic                 we_ni,
  input  logic                 reg_ni,
  input  logic                 wp_i,
  output logic [NUM_PAIRS-1:0] cs_lo_no,
  output logic [NUM_PAIRS-1:0] cs_hi_no,
  output logic [ARR_AW-1:0]    arr_addr_o,
  output logic                 attr_cs_no,
  output logic                 rd_no,
  output logic                 wr_no,
  output logic                 lane_lo_oe_o,
  output logic                 lane_hi_oe_o,
  output logic                 steer_odd_o,
  output logic                 fill_lo_o,
  output logic                 fill_hi_o,
  output logic                 wait_no
);
  localparam int FIELD_LSB = ARR_AW + 1;
  localparam int USED_TOP  = FIELD_LSB + IDX_W;

  logic unused_hi_addr;
  assign unused_hi_addr = ^addr_i[ADDR_W-1:USED_TOP];

  lane_need_t need;
  logic rd_cyc, wr_cyc, act, flash, any_lane, populated;
  logic [NUM_PAIRS-1:0] pair_sel;

  flc_lane_dec u_lane (
    .ce1_ni(ce1_ni),
    .ce2_ni(ce2_ni),
    .a0_i  (addr_i[0]),
    .need_o(need)
  );

  assign rd_cyc   = !oe_ni && we_ni;
  assign wr_cyc   = oe_ni && !we_ni;
  assign act      = rd_cyc || wr_cyc;
  assign flash    = reg_ni;
  assign any_lane = need.even || need.odd;

  flc_pair_dec #(.NUM_PAIRS(NUM_PAIRS)) u_pair (
    .field_i    (addr_i[FIELD_LSB +: IDX_W]),
    .en_i       (flash && act),
    .sel_o      (pair_sel),
    .populated_o(populated)
  );

  logic [NUM_PAIRS-1:0] cs_lo_d, cs_hi_d;
  logic attr_d, rd_d, wr_d, lo_oe_d, hi_oe_d, fill_lo_d, fill_hi_d;

  always_comb begin
    cs_lo_d   = ~(pair_sel & {NUM_PAIRS{need.even}});
    cs_hi_d   = ~(pair_sel & {NUM_PAIRS{need.odd}});
    attr_d    = !(!flash && act && need.even);
    rd_d      = !(rd_cyc && any_lane);
    wr_d      = !(wr_cyc && any_lane && !(flash && wp_i));
    lo_oe_d   = rd_cyc && !ce1_ni;
    hi_oe_d   = rd_cyc && !ce2_ni;
    // flash: unpopulated hole; attribute: odd positions not valid
    fill_lo_d = lo_oe_d && (flash ? !populated : need.steer);
    fill_hi_d = hi_oe_d && (flash ? !populated : 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_lo_no     <= '1;
      cs_hi_no     <= '1;
      arr_addr_o   <= '0;
      attr_cs_no   <= 1'b1;
      rd_no        <= 1'b1;
      wr_no        <= 1'b1;
      lane_lo_oe_o <= 1'b0;
      lane_hi_oe_o <= 1'b0;
      steer_odd_o  <= 1'b0;
      fill_lo_o    <= 1'b0;
      fill_hi_o    <= 1'b0;
    end else begin
      cs_lo_no     <= cs_lo_d;
      cs_hi_no     <= cs_hi_d;
      arr_addr_o   <= addr_i[1 +: ARR_AW];
      attr_cs_no   <= attr_d;
      rd_no        <= rd_d;
      wr_no        <= wr_d;
      lane_lo_oe_o <= lo_oe_d;
      lane_hi_oe_o <= hi_oe_d;
      steer_odd_o  <= need.steer;
      fill_lo_o    <= fill_lo_d;
      fill_hi_o    <= fill_hi_d;
    end
  end

  assign wait_no = 1'b1;
endmodule

// File: rtl/flc_dec_chk.sv
module flc_dec_chk #(
  parameter int NUM_PAIRS = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ce1_ni,
  input logic                 ce2_ni,
  input logic                 oe_ni,
  input logic                 we_ni,
  input logic                 reg_ni,
  input logic                 wp_i,
  input logic [NUM_PAIRS-1:0] cs_lo_no,
  input logic [NUM_PAIRS-1:0] cs_hi_no,
  input logic                 attr_cs_no,
  input logic                 rd_no,
  input logic                 wr_no,
  input logic                 lane_lo_oe_o,
  input logic                 lane_hi_oe_o,
  input logic                 wait_no
);
  AST_STANDBY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce1_ni && ce2_ni) |=> (&cs_lo_no && &cs_hi_no && attr_cs_no && !lane_lo_oe_o && !lane_hi_oe_o)); // R1

  AST_WORD_BOTH_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce1_ni && !ce2_ni && !oe_ni && we_ni) |=> (lane_lo_oe_o && lane_hi_oe_o)); // R4

  AST_STROBE_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ni == we_ni) |=> (rd_no && wr_no && &cs_lo_no && &cs_hi_no && attr_cs_no)); // R6

  AST_ONE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_lo_no) && $onehot0(~cs_hi_no)); // R7

  AST_WP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_i && reg_ni) |=> wr_no); // R9

  AST_ATTR_NO_FLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_ni |=> (&cs_lo_no && &cs_hi_no)); // R10

  always @(posedge clk_i) begin
    if (rst_ni) begin
      AST_WAIT_HIGH: assert (wait_no); // R11
    end
  end
endmodule

bind flc_dec flc_dec_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce1_ni      (ce1_ni),
  .ce2_ni      (ce2_ni),
  .oe_ni       (oe_ni),
  .we_ni       (we_ni),
  .reg_ni      (reg_ni),
  .wp_i        (wp_i),
  .cs_lo_no    (cs_lo_no),
  .cs_hi_no    (cs_hi_no),
  .attr_cs_no  (attr_cs_no),
  .rd_no       (rd_no),
  .wr_no       (wr_no),
  .lane_lo_oe_o(lane_lo_oe_o),
  .lane_hi_oe_o(lane_hi_oe_o),
  .wait_no     (wait_no)
);

// File: tb/tb_flc_dec.sv
module tb_flc_dec;
  localparam int NP = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [25:0] addr_i = '0;
  logic ce1_ni = 1'b1, ce2_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1, reg_ni = 1'b1, wp_i = 1'b0;
  logic [NP-1:0] cs_lo_no, cs_hi_no;
  logic [18:0] arr_addr_o;
  logic attr_cs_no, rd_no, wr_no, lane_lo_oe_o, lane_hi_oe_o, steer_odd_o, fill_lo_o, fill_hi_o, wait_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  flc_dec #(.NUM_PAIRS(NP)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i),
    .ce1_ni(ce1_ni), .ce2_ni(ce2_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .reg_ni(reg_ni), .wp_i(wp_i),
    .cs_lo_no(cs_lo_no), .cs_hi_no(cs_hi_no), .arr_addr_o(arr_addr_o),
    .attr_cs_no(attr_cs_no), .rd_no(rd_no), .wr_no(wr_no),
    .lane_lo_oe_o(lane_lo_oe_o), .lane_hi_oe_o(lane_hi_oe_o),
    .steer_odd_o(steer_odd_o), .fill_lo_o(fill_lo_o), .fill_hi_o(fill_hi_o),
    .wait_no(wait_no)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    #12;
    chk("R12", "cs_lo", 32'(cs_lo_no), 32'h7);
    chk("R12", "cs_hi", 32'(cs_hi_no), 32'h7);
    chk("R12", "strobes", {29'd0, attr_cs_no, rd_no, wr_no}, 32'h7);
    chk("R12", "flags", {27'd0, lane_lo_oe_o, lane_hi_oe_o, steer_odd_o, fill_lo_o, fill_hi_o}, 32'h0);
    chk("R12", "arr", 32'(arr_addr_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R12 latency: word read to pair 1, output unchanged before the edge
    addr_i = 26'h0100002; ce1_ni = 0; ce2_ni = 0; oe_ni = 0; we_ni = 1; reg_ni = 1;
    #1;
    chk("R12", "pre-edge cs_lo", 32'(cs_lo_no), 32'h7);
    @(negedge clk_i);
    chk("R12", "post-edge cs_lo", 32'(cs_lo_no), 32'h5);

    for (int v = 0; v < 128; v++) begin
      for (int f = 0; f < 16; f++) begin
        logic c1, c2, a0, oe, we, rg, wp, ne, no, st, rd, wr, ac, pop, elo, ehi;
        logic [3:0] pidx;
        logic [NP-1:0] slo, shi;
        logic [25:0] ad;
        string mtag;
        c1 = v[0]; c2 = v[1]; a0 = v[2]; oe = v[3]; we = v[4]; rg = v[5]; wp = v[6];
        ad = {2'b10, 4'(f), 19'(v * 2731 + f * 977), a0};
        addr_i = ad; ce1_ni = c1; ce2_ni = c2; oe_ni = oe; we_ni = we; reg_ni = rg; wp_i = wp;

        ne = !c1 && (!c2 || !a0);
        no = !c2 || (!c1 && a0);
        st = !c1 && c2 && a0;
        rd = !oe && we;
        wr = oe && !we;
        ac = rd || wr;
        pidx = 4'(f) & 4'd3;
        pop = pidx < 4'(NP);
        slo = '1; shi = '1;
        if (rg && ac && pop && ne) slo[pidx[1:0]] = 1'b0;
        if (rg && ac && pop && no) shi[pidx[1:0]] = 1'b0;
        elo = rd && !c1;
        ehi = rd && !c2;
        if (c1 && c2) mtag = "R1";
        else if (!c1 && !c2) mtag = "R4";
        else if (c1) mtag = "R5";
        else if (a0) mtag = "R3";
        else mtag = "R2";

        @(negedge clk_i);
        chk(pop ? "R7" : "R8", "cs_lo", 32'(cs_lo_no), 32'(slo));
        chk(pop ? "R7" : "R8", "cs_hi", 32'(cs_hi_no), 32'(shi));
        chk("R10", "attr_cs", 32'(attr_cs_no), 32'(!(!rg && ac && ne)));
        chk("R6", "rd", 32'(rd_no), 32'(!(rd && (ne || no))));
        chk("R9", "wr", 32'(wr_no), 32'(!(wr && (ne || no) && !(rg && wp))));
        chk(mtag, "lane_lo", 32'(lane_lo_oe_o), 32'(elo));
        chk(mtag, "lane_hi", 32'(lane_hi_oe_o), 32'(ehi));
        chk("R3", "steer", 32'(steer_odd_o), 32'(st));
        chk(rg ? "R8" : "R10", "fill_lo", 32'(fill_lo_o), 32'(elo && (rg ? !pop : st)));
        chk(rg ? "R8" : "R10", "fill_hi", 32'(fill_hi_o), 32'(ehi && (rg ? !pop : 1'b1)));
        chk("R7", "arr", 32'(arr_addr_o), 32'(ad[19:1]));
        chk("R11", "wait", 32'(wait_no), 32'h1);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule